// File: doc/BRIEF.md
# Tagged-Queue Message Acceptor

This block is the target-side sequencer that runs once the device has been selected with the attention line asserted. It asks the initiator for message bytes over a byte-wide request/acknowledge handshake. After the first (identify) byte it looks at the attention line. From that level and the run-time configuration it decides whether to stop after one byte, collect two more bytes (a queue-tag code and a tag value), or abort the selection.

Every accepted message byte goes into a small first-word-fall-through FIFO, in the order it arrived. The queue-tag value is also kept in a holding register. The sequence ends in one of three ways, and each raises an interrupt with a status code that gives the reason: entry into command phase, a halt on an illegal tag code, or an abort. Arbitration, command decoding, DMA and the register interface are not part of this block.

Top module: `tqa_msg_acceptor`

## Requirements
- R1: After reset, `req_out`, `msg_out_phase`, `cmd_phase` and `irq` are 0, `irq_code` is 2'b00 and `fifo_empty` is 1.
- R2: A pulse on `sel_atn_start` raises `req_out` and `msg_out_phase`. A byte is taken on the clock edge where `init_ack` is high while `req_out` is high, and `req_out` then drops. The next request appears only after `init_ack` has returned low.
- R3: The three-byte feature is on when `cfg_scsi2_en` OR `cfg_qtag_en` is 1. Both bits are sampled at the start pulse, so changing them during a sequence has no effect on that sequence.
- R4: With the feature on and `atn_in` high when the first byte is taken, exactly two more bytes are requested. After the third byte is acknowledged, `cmd_phase` rises together with `irq` and `irq_code` = 2'b01 (done).
- R5: In either mode, if `atn_in` is low when the first byte is taken, no further byte is requested. `cmd_phase` rises with `irq` and `irq_code` = 2'b01.
- R6: The second byte is legal only if it is 8'h20, 8'h21 or 8'h22. Any other value ends the sequence with `irq_code` = 2'b10 (bad tag), without command phase, without further requests, and without storing that byte.
- R7: The third byte may be any value 0 to 255. It is stored and presented on `tag_value`.
- R8: With the feature off and `atn_in` high when the first byte is taken, the sequence aborts with `irq_code` = 2'b11. There is no command phase and no further request.
- R9: Accepted bytes leave the FIFO in arrival order: identify, tag code, tag value. `fifo_data` shows the oldest entry, and `fifo_pop` removes it.
- R10: `irq` and `irq_code` hold until a pulse on `irq_clr` (which sets `irq` to 0 and `irq_code` to 2'b00) or until the next start pulse.
- R11: A byte that arrives while the FIFO holds `FIFO_DEPTH` (default 8) entries is dropped. The count stays at the depth and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_atn_start | input | 1 | One-cycle pulse: selected with attention, begin message phase |
| cfg_scsi2_en | input | 1 | SCSI-2 feature enable (turns on the three-byte feature) |
| cfg_qtag_en | input | 1 | Queue-tag enable (turns on the three-byte feature) |
| atn_in | input | 1 | Attention line level from the initiator |
| init_ack | input | 1 | Initiator acknowledge for the current byte |
| init_data | input | 8 | Message byte from the initiator |
| req_out | output | 1 | Target request for a message byte |
| msg_out_phase | output | 1 | High while the message bytes are being collected |
| cmd_phase | output | 1 | Request to enter command phase |
| irq | output | 1 | Interrupt, held until cleared |
| irq_code | output | 2 | Reason: 00 none, 01 done, 10 bad tag, 11 abort |
| irq_clr | input | 1 | Clears the interrupt and its code |
| tag_value | output | 8 | Last accepted tag value |
| fifo_pop | input | 1 | Remove the oldest FIFO entry |
| fifo_data | output | 8 | Oldest FIFO entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_count | output | 4 | Number of FIFO entries |

## Verification
The checker watches several rules on every cycle:
- a request is never outstanding during command phase;
- a request only drops after an acknowledge;
- command phase only rises together with a done interrupt;
- a raised interrupt always carries a non-zero code;
- the FIFO count never exceeds its depth.

Other behaviours depend on the initiator's byte values and the attention level, so only the bench's scenarios can show them. These include how many bytes are requested on each path, the rejection of illegal tag codes, the abort when the feature is off, the latching of the configuration, the FIFO order and the dropping of bytes on overflow.

// File: rtl/tqa_pkg.sv
package tqa_pkg;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_REQ   = 2'd1,
      S_ACKLO = 2'd2,
      S_END   = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      ST_NONE   = 2'b00,
      ST_DONE   = 2'b01,
      ST_BADTAG = 2'b10,
      ST_ABORT  = 2'b11
   } stat_code_t;

   localparam logic [7:0] TAG_CODE_LO = 8'h20;
   localparam logic [7:0] TAG_CODE_HI = 8'h22;

   function automatic logic tag_code_ok(input logic [7:0] b);
      return (b >= TAG_CODE_LO) && (b <= TAG_CODE_HI);
   endfunction

endpackage

// File: rtl/tqa_fifo.sv
module tqa_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              empty_o,
   output logic [CW-1:0]     count_o
);

   if (DEPTH < 3 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("tqa_fifo: DEPTH must be a power of two and at least 3");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
   logic [CW-1:0]     count_q;
   logic              wr_en, rd_en;

   assign wr_en = push_i && (count_q != CW'(DEPTH));
   assign rd_en = pop_i && (count_q != '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_en && (wr_ptr_q == AW'(i))) mem[i] <= din_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (wr_en) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (rd_en) rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign dout_o  = mem[rd_ptr_q];
   assign empty_o = (count_q == '0);
   assign count_o = count_q;

endmodule

// File: rtl/tqa_seq.sv
module tqa_seq
   import tqa_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              feat_a_i,
   input  logic              feat_b_i,
   input  logic              atn_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              irq_clr_i,
   output logic              req_o,
   output logic              msg_phase_o,
   output logic              cmd_phase_o,
   output logic              irq_o,
   output logic [1:0]        irq_code_o,
   output logic [DATA_W-1:0] tag_o,
   output logic              push_o
);

   seq_state_t        state_q;
   logic [1:0]        idx_q;
   logic              atn_q, feat_q, ok_q, irq_q;
   stat_code_t        code_q;
   logic [DATA_W-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         atn_q   <= 1'b0;
         feat_q  <= 1'b0;
         ok_q    <= 1'b0;
         irq_q   <= 1'b0;
         code_q  <= ST_NONE;
         tag_q   <= '0;
      end else begin
         case (state_q)
            S_IDLE, S_END: begin
               if (start_i) begin
                  state_q <= S_REQ;
                  idx_q   <= 2'd0;
                  feat_q  <= feat_a_i | feat_b_i;
                  ok_q    <= 1'b0;
                  irq_q   <= 1'b0;
                  code_q  <= ST_NONE;
               end else if (irq_clr_i) begin
                  irq_q  <= 1'b0;
                  code_q <= ST_NONE;
               end
            end
            S_REQ: begin
               if (ack_i) begin
                  state_q <= S_ACKLO;
                  if (idx_q == 2'd0) atn_q <= atn_i;
                  if (idx_q == 2'd2) tag_q <= data_i;
                  if (idx_q == 2'd1 && !tag_code_ok(data_i)) begin
                     state_q <= S_END;
                     irq_q   <= 1'b1;
                     code_q  <= ST_BADTAG;
                  end
               end
            end
            S_ACKLO: begin
               if (!ack_i) begin
                  if (idx_q == 2'd0 && atn_q && feat_q) begin
                     state_q <= S_REQ;
                     idx_q   <= 2'd1;
                  end else if (idx_q == 2'd1) begin
                     state_q <= S_REQ;
                     idx_q   <= 2'd2;
                  end else if (idx_q == 2'd0 && atn_q) begin
                     state_q <= S_END;
                     irq_q   <= 1'b1;
                     code_q  <= ST_ABORT;
                  end else begin
                     state_q <= S_END;
                     irq_q   <= 1'b1;
                     code_q  <= ST_DONE;
                     ok_q    <= 1'b1;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      push_o = (state_q == S_REQ) && ack_i &&
               ((idx_q != 2'd1) || tag_code_ok(data_i));
   end

   assign req_o       = (state_q == S_REQ);
   assign msg_phase_o = (state_q == S_REQ) || (state_q == S_ACKLO);
   assign cmd_phase_o = (state_q == S_END) && ok_q;
   assign irq_o       = irq_q;
   assign irq_code_o  = code_q;
   assign tag_o       = tag_q;

endmodule

// File: rtl/tqa_msg_acceptor.sv
module tqa_msg_acceptor #(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 8,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_atn_start,
   input  logic              cfg_scsi2_en,
   input  logic              cfg_qtag_en,
   input  logic              atn_in,
   input  logic              init_ack,
   input  logic [DATA_W-1:0] init_data,
   output logic              req_out,
   output logic              msg_out_phase,
   output logic              cmd_phase,
   output logic              irq,
   output logic [1:0]        irq_code,
   input  logic              irq_clr,
   output logic [DATA_W-1:0] tag_value,
   input  logic              fifo_pop,
   output logic [DATA_W-1:0] fifo_data,
   output logic              fifo_empty,
   output logic [CNT_W-1:0]  fifo_count
);

   if (DATA_W != 8) begin : g_width_bad
      $error("tqa_msg_acceptor: message bytes must be 8 bits wide");
   end

   logic push;

   tqa_seq #(.DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (sel_atn_start),
      .feat_a_i    (cfg_scsi2_en),
      .feat_b_i    (cfg_qtag_en),
      .atn_i       (atn_in),
      .ack_i       (init_ack),
      .data_i      (init_data),
      .irq_clr_i   (irq_clr),
      .req_o       (req_out),
      .msg_phase_o (msg_out_phase),
      .cmd_phase_o (cmd_phase),
      .irq_o       (irq),
      .irq_code_o  (irq_code),
      .tag_o       (tag_value),
      .push_o      (push)
   );

   tqa_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   (init_data),
      .pop_i   (fifo_pop),
      .dout_o  (fifo_data),
      .empty_o (fifo_empty),
      .count_o (fifo_count)
   );

endmodule

// File: rtl/tqa_chk.sv
module tqa_chk #(
   parameter int FIFO_DEPTH = 8,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             init_ack,
   input logic             req_out,
   input logic             cmd_phase,
   input logic             irq,
   input logic [1:0]       irq_code,
   input logic [CNT_W-1:0] fifo_count
);

   // R2
   req_drop_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_out) |-> $past(init_ack));

   // R4
   no_req_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_out && cmd_phase));

   // R5
   cmd_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_phase) |-> (irq && irq_code == 2'b01));

   // R10
   irq_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_code != 2'b00));

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(FIFO_DEPTH));

endmodule

bind tqa_msg_acceptor tqa_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .init_ack   (init_ack),
   .req_out    (req_out),
   .cmd_phase  (cmd_phase),
   .irq        (irq),
   .irq_code   (irq_code),
   .fifo_count (fifo_count)
);

// File: tb/tqa_msg_acceptor_bench.sv
`timescale 1ns/1ps
module tqa_msg_acceptor_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_atn_start = 1'b0;
   logic       cfg_scsi2_en = 1'b0;
   logic       cfg_qtag_en = 1'b0;
   logic       atn_in = 1'b0;
   logic       init_ack = 1'b0;
   logic [7:0] init_data = 8'h00;
   logic       irq_clr = 1'b0;
   logic       fifo_pop = 1'b0;
   logic       req_out, msg_out_phase, cmd_phase, irq, fifo_empty;
   logic [1:0] irq_code;
   logic [7:0] tag_value, fifo_data;
   logic [3:0] fifo_count;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   tqa_msg_acceptor u_tqa_msg_acceptor (
      .clk(clk), .rst_n(rst_n), .sel_atn_start(sel_atn_start),
      .cfg_scsi2_en(cfg_scsi2_en), .cfg_qtag_en(cfg_qtag_en),
      .atn_in(atn_in), .init_ack(init_ack), .init_data(init_data),
      .req_out(req_out), .msg_out_phase(msg_out_phase), .cmd_phase(cmd_phase),
      .irq(irq), .irq_code(irq_code), .irq_clr(irq_clr),
      .tag_value(tag_value), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
      .fifo_empty(fifo_empty), .fifo_count(fifo_count)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 'h%0h expected 'h%0h", req, act, exp);
      end
   endtask

   task automatic wait_req(input logic lvl);
      do @(negedge clk); while (req_out !== lvl);
   endtask

   task automatic start_seq(input logic s2, input logic qt);
      @(negedge clk);
      cfg_scsi2_en  = s2;
      cfg_qtag_en   = qt;
      sel_atn_start = 1'b1;
      @(negedge clk);
      sel_atn_start = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input logic atn);
      wait_req(1'b1);
      init_data = b;
      atn_in    = atn;
      init_ack  = 1'b1;
      wait_req(1'b0);
      init_ack  = 1'b0;
   endtask

   task automatic wait_irq();
      while (irq !== 1'b1) @(negedge clk);
   endtask

   task automatic expect_quiet(input string req);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(req_out == 1'b0, req, req_out, 0);
      end
   endtask

   task automatic pop_expect(input logic [7:0] exp, input string req);
      @(negedge clk);
      chk(fifo_data == exp && !fifo_empty, req, fifo_data, exp);
      fifo_pop = 1'b1;
      @(negedge clk);
      fifo_pop = 1'b0;
   endtask

   task automatic drain();
      while (!fifo_empty) begin
         fifo_pop = 1'b1;
         @(negedge clk);
      end
      fifo_pop = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!req_out && !msg_out_phase && !cmd_phase && !irq && irq_code == 2'b00 && fifo_empty,
          "R1 reset state", {req_out, msg_out_phase, cmd_phase, irq, irq_code, fifo_empty}, 7'b0000001);
   endtask

   task automatic t_one_byte(input logic s2, input logic qt, input logic [7:0] id);
      start_seq(s2, qt);
      chk(req_out && msg_out_phase, "R2 request after start", {req_out, msg_out_phase}, 2'b11);
      send_byte(id, 1'b0);
      wait_irq();
      chk(cmd_phase && irq_code == 2'b01, "R5 atn low gives command phase",
          {cmd_phase, irq_code}, 3'b101);
      expect_quiet("R5 no further request");
      chk(fifo_count == 4'd1, "R5 one byte stored", fifo_count, 1);
      pop_expect(id, "R9 identify byte");
   endtask

   task automatic t_three(input logic s2, input logic qt, input logic [7:0] id,
                          input logic [7:0] code, input logic [7:0] val, input logic flip_cfg);
      start_seq(s2, qt);
      if (flip_cfg) begin
         cfg_scsi2_en = 1'b0;
         cfg_qtag_en  = 1'b0;
      end
      send_byte(id, 1'b1);
      @(negedge clk);
      @(negedge clk);
      chk(req_out == 1'b1, "R2 second request after ack low", req_out, 1);
      send_byte(code, 1'b1);
      send_byte(val, 1'b0);
      wait_irq();
      chk(cmd_phase && irq_code == 2'b01, flip_cfg ? "R3 latched config keeps three-byte path"
                                                   : "R4 three-byte path done",
          {cmd_phase, irq_code}, 3'b101);
      chk(tag_value == val, "R7 tag value stored", tag_value, val);
      chk(fifo_count == 4'd3, "R4 three bytes stored", fifo_count, 3);
      pop_expect(id,   "R9 order identify");
      pop_expect(code, "R9 order tag code");
      pop_expect(val,  "R9 order tag value");
   endtask

   task automatic t_bad_tag(input logic [7:0] code);
      start_seq(1'b1, 1'b0);
      send_byte(8'hC1, 1'b1);
      send_byte(code, 1'b1);
      wait_irq();
      chk(irq_code == 2'b10 && !cmd_phase, "R6 bad tag halts",
          {cmd_phase, irq_code}, 3'b010);
      expect_quiet("R6 no request after bad tag");
      chk(fifo_count == 4'd1, "R6 bad code not stored", fifo_count, 1);
      pop_expect(8'hC1, "R6 identify kept");
   endtask

   task automatic t_abort();
      start_seq(1'b0, 1'b0);
      send_byte(8'h80, 1'b1);
      wait_irq();
      chk(irq_code == 2'b11 && !cmd_phase, "R8 disabled with atn aborts",
          {cmd_phase, irq_code}, 3'b011);
      expect_quiet("R8 no request after abort");
      drain();
   endtask

   task automatic t_irq_clear();
      t_one_byte(1'b0, 1'b1, 8'h81);
      chk(irq == 1'b1, "R10 irq held", irq, 1);
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(!irq && irq_code == 2'b00, "R10 irq cleared", {irq, irq_code}, 0);
   endtask

   task automatic t_overflow();
      logic [7:0] exp [8];
      exp = '{8'hC0, 8'h20, 8'h11, 8'hC1, 8'h21, 8'h22, 8'hC2, 8'h22};
      for (int s = 0; s < 3; s++) begin
         start_seq(1'b1, 1'b1);
         send_byte(8'hC0 + 8'(s), 1'b1);
         send_byte(8'h20 + 8'(s), 1'b1);
         send_byte(8'h11 + 8'(s) * 8'h11, 1'b0);
         wait_irq();
      end
      chk(fifo_count == 4'd8, "R11 count saturates at depth", fifo_count, 8);
      chk(tag_value == 8'h33, "R7 tag value of last sequence", tag_value, 8'h33);
      for (int i = 0; i < 8; i++) pop_expect(exp[i], "R11 stored entries unchanged");
      chk(fifo_empty == 1'b1, "R11 extra byte dropped", fifo_empty, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_one_byte(1'b1, 1'b0, 8'hC0);
      t_one_byte(1'b0, 1'b0, 8'h80);
      t_three(1'b1, 1'b0, 8'hC3, 8'h21, 8'hA5, 1'b0);
      t_three(1'b0, 1'b1, 8'hC4, 8'h22, 8'hFF, 1'b1);
      t_three(1'b1, 1'b1, 8'hC5, 8'h20, 8'h00, 1'b0);
      t_bad_tag(8'h23);
      t_bad_tag(8'h1F);
      t_abort();
      t_irq_clear();
      t_overflow();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule